// File: doc/BRIEF.md
# Approximate Logarithmic Multiplier

This block multiplies two unsigned 8-bit operands approximately. It does not use an array of partial products. It moves both operands into the base-2 logarithm domain, adds them there, and converts the sum back. Each operand gives an integer part and a fraction. The integer part is the position of its highest set bit. The fraction is the bits below that bit, shifted up so they sit at the top of an 8-bit fraction. This treats the logarithm curve as a straight line between consecutive powers of two.

The two logarithms and a fixed bias of 17/256 go into a single three-input adder. The bias moves the error band so that it is centred on zero, which keeps the worst relative error near 7% instead of about 11%. The sum is converted back with the same straight-line rule: the mantissa (1 + fraction) is shifted left by the integer part, and the fraction bits are dropped. Products that would not fit in 16 bits are clamped to the largest value. A zero operand bypasses this path and produces zero.

The datapath is combinational and ends in one output register, qualified by a valid strobe. Operands can arrive on every cycle.

Top module: `log_mult`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and `product` is 0.
- R2: A cycle with `in_valid` high sets `out_valid` high on the next cycle, with that cycle's result on `product`. A cycle with `in_valid` low clears `out_valid` on the next cycle, and `product` keeps its previous value whatever `a` and `b` hold.
- R3: If either operand is 0, the product is exactly 0.
- R4: An operand's logarithm has an integer part equal to the bit index of its highest 1. Its 8-bit fraction is the bits below that 1, left-aligned. So 46 maps to 5 + 0.4375, and 46 x 1 gives 48.
- R5: The adder adds 17/256 to the two logarithms. So 1 x 1 gives 1 and 128 x 128 gives 17472.
- R6: A log sum with integer K and fraction F (in 256ths) converts back to floor((256 + F) * 2^K / 256). So 3 x 3 gives 8, 192 x 192 gives 34944, and 255 x 128 gives 34688.
- R7: A log sum whose integer part is 16 or more gives 65535. So 255 x 255 gives 65535.
- R8: For every pair of non-zero operands, |product - a*b| <= 0.072 * a*b + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on `a` and `b` are to be multiplied |
| a | input | 8 | First unsigned operand |
| b | input | 8 | Second unsigned operand |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 16 | Approximate unsigned product |

## Verification
Every result appears exactly one clock edge after the cycle in which its operands were accepted. The driver pushes each operand pair into a queue as it applies the pair on a falling edge. The monitor pops one entry on each later falling edge where `out_valid` is high, so results are compared in order and away from the edge that updates them. Named corner pairs are compared against exact hand-derived values. A sweep over all 65536 operand pairs, one per cycle, is checked against the error bound. Zero-operand pairs in the sweep are checked for an exact zero. An idle window after a result confirms that the strobe clears and the held product stays fixed while the operands change.

// File: rtl/log_mult.sv
module log_mult #(
  parameter int W    = 8,
  parameter int FW   = 8,
  parameter int PW   = 16,
  parameter int CORR = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic          out_valid,
  output logic [PW-1:0] product
);
  localparam int KW = $clog2(W);
  localparam int IW = KW + 2;
  localparam int SW = IW + FW;
  localparam int AW = FW + 1 + (1 << IW);

  function automatic logic [KW-1:0] lead_pos(input logic [W-1:0] x);
    logic [KW-1:0] p;
    p = '0;
    for (int i = 0; i < W; i++)
      if (x[i]) p = KW'(i);
    return p;
  endfunction

  function automatic logic [FW-1:0] frac_of(input logic [W-1:0] x, input logic [KW-1:0] k);
    logic [KW-1:0]   amt;
    logic [W-1:0]    sh;
    logic [FW+W-1:0] wide;
    amt  = KW'(W - 1) - k;
    sh   = x << amt;
    wide = {sh[W-2:0], {(FW + 1){1'b0}}};
    return wide[FW+W-1 -: FW];
  endfunction

  logic [KW-1:0] ka, kb;
  logic [FW-1:0] fa, fb;
  logic [SW-1:0] lsum;
  logic [IW-1:0] kint;
  logic [FW:0]   mant;
  logic [AW-1:0] grown, scaled;
  logic          zero_in, too_big;
  logic [PW-1:0] result;

  assign ka = lead_pos(a);
  assign kb = lead_pos(b);
  assign fa = frac_of(a, ka);
  assign fb = frac_of(b, kb);

  assign lsum = SW'({ka, fa}) + SW'({kb, fb}) + SW'(CORR);
  assign kint = lsum[SW-1:FW];
  assign mant = {1'b1, lsum[FW-1:0]};

  assign grown   = AW'(mant) << kint;
  assign scaled  = grown >> FW;
  assign too_big = |scaled[AW-1:PW];
  assign zero_in = (a == '0) || (b == '0);

  always_comb begin
    if (zero_in)      result = '0;
    else if (too_big) result = '1;
    else              result = scaled[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= result;
    end
  end
endmodule

// File: rtl/log_mult_checker.sv
module log_mult_checker #(
  parameter int W  = 8,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  a,
  input logic [W-1:0]  b,
  input logic          out_valid,
  input logic [PW-1:0] product
);
  logic [31:0] exact, scaled_out;
  logic        nz;
  assign exact      = 32'(a) * 32'(b);
  assign scaled_out = 32'(product) * 32'd1000;
  assign nz         = (a != '0) && (b != '0);

  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));  // R2
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nz) |=> (product == '0));  // R3
  AST_ERR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nz) |=> (scaled_out <= $past(exact) * 32'd1072 + 32'd1000));  // R8
  AST_ERR_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nz) |=> (scaled_out + 32'd1000 >= $past(exact) * 32'd928));  // R8
endmodule

bind log_mult log_mult_checker #(.W(W), .PW(PW)) u_log_mult_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .product(product)
);

// File: tb/log_mult_bench.sv
`timescale 1ns/1ps
module log_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  a = '0, b = '0;
  logic        out_valid;
  logic [15:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [32:0] sb_q[$];

  always #2.5 clk = ~clk;

  log_mult u_log_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .product(product)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] x, input logic [7:0] y, input bit bound, input logic [15:0] exp);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    sb_q.push_back({bound, x, y, exp});
  endtask

  task automatic go_idle(input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected result", int'(product), -1);
      end else begin
        logic [32:0] it;
        int ex, lhs;
        it = sb_q.pop_front();
        if (it[32]) begin
          ex  = int'(it[31:24]) * int'(it[23:16]);
          lhs = 1000 * ((int'(product) > ex) ? int'(product) - ex : ex - int'(product));
          check(lhs <= 72 * ex + 1000, "R8 error bound", int'(product), ex);
        end else begin
          check(product == it[15:0], "R3/R4/R5/R6/R7 product", int'(product), int'(it[15:0]));
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(product == 16'd0, "R1 product in reset", int'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(product == 16'd0, "R1 product after reset", int'(product), 0);

    send(8'd46, 8'd1, 1'b0, 16'd48);         // R4
    go_idle(8'd200, 8'd200);
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 strobe clears", int'(out_valid), 0);
    check(product == 16'd48, "R2 product held", int'(product), 48);

    send(8'd0, 8'd77, 1'b0, 16'd0);          // R3
    send(8'd91, 8'd0, 1'b0, 16'd0);          // R3
    send(8'd1, 8'd1, 1'b0, 16'd1);           // R5
    send(8'd128, 8'd128, 1'b0, 16'd17472);   // R5
    send(8'd3, 8'd3, 1'b0, 16'd8);           // R6
    send(8'd192, 8'd192, 1'b0, 16'd34944);   // R6
    send(8'd255, 8'd128, 1'b0, 16'd34688);   // R6
    send(8'd255, 8'd255, 1'b0, 16'd65535);   // R7
    send(8'd1, 8'd46, 1'b0, 16'd48);         // R4

    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        if (i == 0 || j == 0) send(8'(i), 8'(j), 1'b0, 16'd0);  // R3
        else                  send(8'(i), 8'(j), 1'b1, 16'd0);  // R8
      end
    end
    go_idle(8'd0, 8'd0);
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R2 all results returned", sb_q.size(), 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule